// File: doc/BRIEF.md
# Ordered-Set Symbol Detector

This block sits behind an 8b/10b decoder on one serial lane. Each clock it takes one decoded character and a flag that says whether the character is a control (K) code or a data (D) code. It looks for the comma control character that opens every link-management ordered set. It then follows the set to its end and checks each character against the codes that set type allows.

Three short sets are recognised, each made of four characters: skip, electrical idle and fast training. Two long training sets are recognised, each made of sixteen characters. For each set the block raises a one-cycle detection pulse together with a type code. For a training set it also presents the fifteen characters that followed the comma. A set that breaks the rules raises a one-cycle error pulse instead, and the block goes back to hunting for a comma.

The link training logic downstream consumes these pulses. Lane deskew and decoding happen upstream of this block.

Top module: `ordset_detector`

## Requirements
- R1: After reset, and while no set is in progress, osPulse and osErr are 0 and osType is 0. A reset in the middle of a set discards that set, so the remaining characters of that set produce no pulse.
- R2: The four characters comma (K 0xBC), K 0x1C, K 0x1C, K 0x1C produce osPulse with osType 3 (skip).
- R3: The four characters comma, K 0x7C, K 0x7C, K 0x7C produce osPulse with osType 4 (electrical idle).
- R4: The four characters comma, K 0x3C, K 0x3C, K 0x3C produce osPulse with osType 5 (fast training).
- R5: In a short set, a second or third identifier that differs from the first, or that is flagged as data, produces an osErr pulse with no osPulse. The block then hunts for a comma, so a following non-comma character produces nothing.
- R6: A comma that arrives inside a set produces an osErr pulse and starts a new set. A complete set that begins with that comma is then detected normally.
- R7: A comma, followed by fifteen characters of which the first is a data character and the last is data 0x4A, produces osPulse with osType 1 (training one). Nothing is reported before the sixteenth character.
- R8: The same framing with data 0x45 as the last character produces osType 2 (training two). Control characters other than the comma are allowed in positions 2 to 14.
- R9: In the cycle of a training pulse, tsData byte k (bits 8k+7:8k) holds character k+1 after the comma, for k from 0 to 14. tsData changes only while a training set is being collected.
- R10: A training set whose sixteenth character is neither data 0x4A nor data 0x45 produces osErr and no osPulse.
- R11: A control character after the comma that is not a skip, idle or fast-training identifier produces osErr.
- R12: Results are registered: a pulse appears in the cycle after the last character is sampled and lasts one cycle. osPulse and osErr are never high together. Sets sent back to back, with no gap between them, are each detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one character is sampled per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| symIn | input | 8 | Decoded character |
| symIsCtrl | input | 1 | 1 when symIn is a control (K) character |
| osPulse | output | 1 | One-cycle pulse when a well-formed set has ended |
| osType | output | 3 | Set type while osPulse is high, otherwise 0 |
| osErr | output | 1 | One-cycle pulse for a malformed set |
| tsData | output | 120 | The fifteen characters after the comma of the latest training set |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Comma inside a set.** A design that ignored the comma would flag the set as malformed but lose the fresh set behind it. A design that raised no error would hide the broken set.
- **Identifiers.** The bench sends a correct code with the data flag set, and mixes two different identifiers in one short set. A design that compared only the code value, or only the first identifier, would report a set that never arrived.
- **Training sets.** A design that counted one character short or one too many would pulse a cycle early or late, or misplace tsData bytes. Both errors show up at the sixteenth character. A bad final identifier catches a design that classifies training sets by default.
- **Back-to-back sets and reset.** Sets with no gap between them, and a reset in the middle of a set, catch a design that needs an idle cycle between sets or keeps stale progress across reset.

// File: rtl/ordset_pkg.sv
package ordset_pkg;
  localparam int SLOT_W = 4;

  typedef enum logic [2:0] {
    OS_NONE = 3'd0,
    OS_TS1  = 3'd1,
    OS_TS2  = 3'd2,
    OS_SKIP = 3'd3,
    OS_IDLE = 3'd4,
    OS_FTS  = 3'd5
  } osKind_e;

  // classification of the current character, datapath -> control
  typedef struct packed {
    logic isCtrl;
    logic isComma;
    logic isSkip;
    logic isIdle;
    logic isFts;
    logic isTs1;
    logic isTs2;
  } symClass_t;

  // strobes, control -> datapath
  typedef struct packed {
    logic              capture;
    logic [SLOT_W-1:0] slot;
  } dpStrobe_t;
endpackage

// File: rtl/ordset_datapath.sv
module ordset_datapath
  import ordset_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int TAIL_LEN = 15,
  parameter logic [SYM_W-1:0] COMMA_SYM = 8'hBC,
  parameter logic [SYM_W-1:0] SKIP_SYM = 8'h1C,
  parameter logic [SYM_W-1:0] IDLE_SYM = 8'h7C,
  parameter logic [SYM_W-1:0] FTS_SYM = 8'h3C,
  parameter logic [SYM_W-1:0] TS1_SYM = 8'h4A,
  parameter logic [SYM_W-1:0] TS2_SYM = 8'h45
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [SYM_W-1:0]          symIn,
  input  logic                      symIsCtrl,
  input  dpStrobe_t                 strobe,
  output symClass_t                 cls,
  output logic [TAIL_LEN*SYM_W-1:0] tsData
);

  always_comb begin
    cls.isCtrl  = symIsCtrl;
    cls.isComma = symIsCtrl && (symIn == COMMA_SYM);
    cls.isSkip  = symIsCtrl && (symIn == SKIP_SYM);
    cls.isIdle  = symIsCtrl && (symIn == IDLE_SYM);
    cls.isFts   = symIsCtrl && (symIn == FTS_SYM);
    cls.isTs1   = !symIsCtrl && (symIn == TS1_SYM);
    cls.isTs2   = !symIsCtrl && (symIn == TS2_SYM);
  end

  // one register per tail position, written when the control names it
  for (genvar g = 0; g < TAIL_LEN; g++) begin : gTail
    logic [SYM_W-1:0] slotReg;
    always_ff @(posedge clk) begin
      if (!rstN) slotReg <= '0;
      else if (strobe.capture && (strobe.slot == SLOT_W'(g))) slotReg <= symIn;
    end
    assign tsData[g*SYM_W +: SYM_W] = slotReg;
  end

  // R9: the captured tail only moves while the control captures
  a_r9_tail_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(tsData));

endmodule

// File: rtl/ordset_ctrl.sv
module ordset_ctrl
  import ordset_pkg::*;
#(
  parameter int TAIL_LEN = 15,
  parameter int SHORT_LEN = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  symClass_t cls,
  output dpStrobe_t strobe,
  output logic      osPulse,
  output osKind_e   osKind,
  output logic      osErr
);

  localparam logic [SLOT_W-1:0] SHORT_LAST = SLOT_W'(SHORT_LEN - 1);
  localparam logic [SLOT_W-1:0] TRAIN_LAST = SLOT_W'(TAIL_LEN);

  typedef enum logic [1:0] {ST_HUNT, ST_FIRST, ST_SHORT, ST_TRAIN} state_e;

  state_e            state, stateN;
  logic [SLOT_W-1:0] pos, posN;
  osKind_e           shortKind, shortKindN;
  logic              pulseN, errN;
  osKind_e           kindN;
  logic              idMatch;

  always_comb begin
    unique case (shortKind)
      OS_SKIP: idMatch = cls.isSkip;
      OS_IDLE: idMatch = cls.isIdle;
      OS_FTS:  idMatch = cls.isFts;
      default: idMatch = 1'b0;
    endcase
  end

  always_comb begin
    stateN         = state;
    posN           = pos;
    shortKindN     = shortKind;
    pulseN         = 1'b0;
    errN           = 1'b0;
    kindN          = OS_NONE;
    strobe.capture = 1'b0;
    strobe.slot    = '0;
    unique case (state)
      ST_HUNT: begin
        if (cls.isComma) stateN = ST_FIRST;
      end
      ST_FIRST: begin
        if (cls.isComma) begin
          errN = 1'b1;
        end else if (cls.isSkip || cls.isIdle || cls.isFts) begin
          stateN     = ST_SHORT;
          posN       = SLOT_W'(2);
          shortKindN = cls.isSkip ? OS_SKIP : (cls.isIdle ? OS_IDLE : OS_FTS);
        end else if (!cls.isCtrl) begin
          stateN         = ST_TRAIN;
          posN           = SLOT_W'(2);
          strobe.capture = 1'b1;
          strobe.slot    = '0;
        end else begin
          errN   = 1'b1;
          stateN = ST_HUNT;
        end
      end
      ST_SHORT: begin
        if (cls.isComma) begin
          errN   = 1'b1;
          stateN = ST_FIRST;
        end else if (idMatch) begin
          if (pos == SHORT_LAST) begin
            pulseN = 1'b1;
            kindN  = shortKind;
            stateN = ST_HUNT;
          end else begin
            posN = pos + 1'b1;
          end
        end else begin
          errN   = 1'b1;
          stateN = ST_HUNT;
        end
      end
      ST_TRAIN: begin
        if (cls.isComma) begin
          errN   = 1'b1;
          stateN = ST_FIRST;
        end else begin
          strobe.capture = 1'b1;
          strobe.slot    = pos - 1'b1;
          if (pos == TRAIN_LAST) begin
            stateN = ST_HUNT;
            if (cls.isTs1) begin
              pulseN = 1'b1;
              kindN  = OS_TS1;
            end else if (cls.isTs2) begin
              pulseN = 1'b1;
              kindN  = OS_TS2;
            end else begin
              errN = 1'b1;
            end
          end else begin
            posN = pos + 1'b1;
          end
        end
      end
      default: stateN = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      pos       <= '0;
      shortKind <= OS_NONE;
      osPulse   <= 1'b0;
      osErr     <= 1'b0;
      osKind    <= OS_NONE;
    end else begin
      state     <= stateN;
      pos       <= posN;
      shortKind <= shortKindN;
      osPulse   <= pulseN;
      osErr     <= errN;
      osKind    <= kindN;
    end
  end

  // R12: detection and error never coincide
  a_r12_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(osPulse && osErr));
  // R12: a detection lasts exactly one cycle
  a_r12_single: assert property (@(posedge clk) disable iff (!rstN)
    osPulse |=> !osPulse);
  // R2: a short set always ends on a control character
  a_r2_short_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    (osPulse && (osKind inside {OS_SKIP, OS_IDLE, OS_FTS})) |-> $past(cls.isCtrl));
  // R7: a training set always ends on a data character
  a_r7_train_data: assert property (@(posedge clk) disable iff (!rstN)
    (osPulse && (osKind inside {OS_TS1, OS_TS2})) |-> !$past(cls.isCtrl));
  // R6: a comma inside a set flags an error and restarts
  a_r6_restart: assert property (@(posedge clk) disable iff (!rstN)
    (cls.isComma && (state != ST_HUNT)) |=> (osErr && (state == ST_FIRST)));

endmodule

// File: rtl/ordset_detector.sv
module ordset_detector
  import ordset_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int TAIL_LEN = 15,
  parameter int SHORT_LEN = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [SYM_W-1:0]          symIn,
  input  logic                      symIsCtrl,
  output logic                      osPulse,
  output logic [2:0]                osType,
  output logic                      osErr,
  output logic [TAIL_LEN*SYM_W-1:0] tsData
);

  symClass_t cls;
  dpStrobe_t strobe;
  osKind_e   kind;

  ordset_datapath #(.SYM_W(SYM_W), .TAIL_LEN(TAIL_LEN)) uDatapath (
    .clk(clk), .rstN(rstN), .symIn(symIn), .symIsCtrl(symIsCtrl),
    .strobe(strobe), .cls(cls), .tsData(tsData)
  );

  ordset_ctrl #(.TAIL_LEN(TAIL_LEN), .SHORT_LEN(SHORT_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .cls(cls), .strobe(strobe),
    .osPulse(osPulse), .osKind(kind), .osErr(osErr)
  );

  assign osType = kind;

endmodule

// File: tb/tb_ordset_detector.sv
module tb_ordset_detector;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   symIn = 8'h00;
  logic         symIsCtrl = 1'b0;
  logic         osPulse;
  logic [2:0]   osType;
  logic         osErr;
  logic [119:0] tsData;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ordset_detector dut (
    .clk(clk), .rstN(rstN), .symIn(symIn), .symIsCtrl(symIsCtrl),
    .osPulse(osPulse), .osType(osType), .osErr(osErr), .tsData(tsData)
  );

  // entry = {ctrl, symbol, expected type, expected error}
  localparam int NVEC = 32;
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 3'd0, 1'b0},                                  // R1
    {1'b1, 8'hBC, 3'd0, 1'b0}, {1'b1, 8'h1C, 3'd0, 1'b0},       // R2
    {1'b1, 8'h1C, 3'd0, 1'b0}, {1'b1, 8'h1C, 3'd3, 1'b0},
    {1'b1, 8'hBC, 3'd0, 1'b0}, {1'b1, 8'h7C, 3'd0, 1'b0},       // R3
    {1'b1, 8'h7C, 3'd0, 1'b0}, {1'b1, 8'h7C, 3'd4, 1'b0},
    {1'b1, 8'hBC, 3'd0, 1'b0}, {1'b1, 8'h3C, 3'd0, 1'b0},       // R4
    {1'b1, 8'h3C, 3'd0, 1'b0}, {1'b1, 8'h3C, 3'd5, 1'b0},
    {1'b1, 8'hBC, 3'd0, 1'b0}, {1'b1, 8'h1C, 3'd0, 1'b0},       // R5 mixed ids
    {1'b1, 8'h7C, 3'd0, 1'b1}, {1'b0, 8'h00, 3'd0, 1'b0},
    {1'b1, 8'hBC, 3'd0, 1'b0}, {1'b1, 8'h1C, 3'd0, 1'b0},       // R5 data flag
    {1'b0, 8'h1C, 3'd0, 1'b1},
    {1'b1, 8'hBC, 3'd0, 1'b0}, {1'b1, 8'h1C, 3'd0, 1'b0},       // R6
    {1'b1, 8'hBC, 3'd0, 1'b1}, {1'b1, 8'h3C, 3'd0, 1'b0},
    {1'b1, 8'h3C, 3'd0, 1'b0}, {1'b1, 8'h3C, 3'd5, 1'b0},
    {1'b1, 8'hBC, 3'd0, 1'b0}, {1'b1, 8'h1C, 3'd0, 1'b0},       // R12 back to back
    {1'b1, 8'h1C, 3'd0, 1'b0}, {1'b1, 8'h1C, 3'd3, 1'b0},
    {1'b1, 8'hBC, 3'd0, 1'b0}, {1'b1, 8'hF7, 3'd0, 1'b1}        // R11
  };

  function automatic string tagOf(int i);
    if (i == 0) return "R1";
    if (i <= 4) return "R2";
    if (i <= 8) return "R3";
    if (i <= 12) return "R4";
    if (i <= 19) return "R5";
    if (i <= 25) return "R6";
    if (i <= 29) return "R12";
    return "R11";
  endfunction

  task automatic check(string req, logic expPulse, logic [2:0] expType, logic expErr);
    checks++;
    if (osPulse !== expPulse || osType !== expType || osErr !== expErr) begin
      fails++;
      $display("FAIL %s: pulse/type/err = %0b/%0d/%0b, expected %0b/%0d/%0b",
               req, osPulse, osType, osErr, expPulse, expType, expErr);
    end
  endtask

  task automatic checkData(string req, logic [119:0] exp);
    checks++;
    if (tsData !== exp) begin
      fails++;
      $display("FAIL %s: tsData = %h, expected %h", req, tsData, exp);
    end
  endtask

  // drive one character, then wait until just after the edge that samples it
  task automatic send(logic ctrl, logic [7:0] sym);
    @(negedge clk);
    symIsCtrl = ctrl;
    symIn = sym;
    @(posedge clk);
    #1;
  endtask

  // comma, then chars 1..14 as data k (or a control filler at position 5), then the last
  task automatic sendTrain(logic padCtrl, logic lastCtrl, logic [7:0] lastSym,
                           output logic [119:0] expData);
    expData = '0;
    send(1'b1, 8'hBC);
    for (int k = 1; k <= 14; k++) begin
      if (padCtrl && k == 5) begin
        send(1'b1, 8'hF7);
        expData[(k-1)*8 +: 8] = 8'hF7;
      end else begin
        send(1'b0, 8'(k));
        expData[(k-1)*8 +: 8] = 8'(k);
      end
      if (k == 14) check("R7 nothing before last char", 1'b0, 3'd0, 1'b0);
    end
    send(lastCtrl, lastSym);
    expData[14*8 +: 8] = lastSym;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [119:0] expD;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", 1'b0, 3'd0, 1'b0);
    checkData("R1 reset tail", '0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][12], VEC[i][11:4]);
      check(tagOf(i), VEC[i][3:1] != 3'd0, VEC[i][3:1], VEC[i][0]);
    end

    // R7 / R9: training one
    sendTrain(1'b0, 1'b0, 8'h4A, expD);
    check("R7 training one", 1'b1, 3'd1, 1'b0);
    checkData("R9 tail layout", expD);
    send(1'b0, 8'h00);
    check("R12 pulse one cycle", 1'b0, 3'd0, 1'b0);
    checkData("R9 tail held when idle", expD);

    // R8: training two with a control filler
    sendTrain(1'b1, 1'b0, 8'h45, expD);
    check("R8 training two", 1'b1, 3'd2, 1'b0);
    checkData("R9 tail with filler", expD);

    // R10: bad final identifier, then a control-flagged 0x4A
    sendTrain(1'b0, 1'b0, 8'h00, expD);
    check("R10 bad last id", 1'b0, 3'd0, 1'b1);
    sendTrain(1'b0, 1'b1, 8'h4A, expD);
    check("R10 last id as control", 1'b0, 3'd0, 1'b1);

    // R6: comma in the middle of a training set, then a skip set
    send(1'b1, 8'hBC);
    for (int k = 1; k <= 7; k++) send(1'b0, 8'h11);
    send(1'b1, 8'hBC);
    check("R6 comma in training set", 1'b0, 3'd0, 1'b1);
    send(1'b1, 8'h1C);
    send(1'b1, 8'h1C);
    send(1'b1, 8'h1C);
    check("R6 restart detects skip", 1'b1, 3'd3, 1'b0);

    // R1: reset in the middle of a set
    send(1'b1, 8'hBC);
    send(1'b1, 8'h1C);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rstN = 1'b1;
    send(1'b1, 8'h1C);
    send(1'b1, 8'h1C);
    check("R1 reset discards set", 1'b0, 3'd0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule